// File: doc/BRIEF.md
# NAND Page Array Engine

This block is the array side of a small-page NAND flash model. It holds the whole flash contents in an on-chip byte array. Each page is laid out as its main data area followed directly by a spare area one thirty-second of that size, and pages sit back to back. A fixed power of two of consecutive pages forms one erase block. A command front end issues one request at a time: stream a page out starting at a column, program streamed bytes into a page, or erase the block that holds a page.

Programming follows flash rules. Each new byte is ANDed into the stored byte, so bits can only go from one to zero. Erase is the only way back to ones. A request that names a page past the end of the array leaves the array alone and raises an error flag. The front end can report this flag as bit 0 of its status. Page data moves over valid/ready byte streams. The write stream is accepted only while a program is running. The read stream may be stalled at any byte by holding `rd_ready` low, and the stream holds `rd_valid` and `rd_data` until the byte is taken. Request and status pins are plain level signals.

After reset the engine sweeps the whole array to 0xFF, one byte per cycle, and holds `busy` high while it does so. Erase also writes one byte per cycle. Program and load move one byte per accepted stream beat.

Top module: `nand_array_engine`

## Requirements
- R1: After reset, `busy` stays high for exactly MEM_BYTES cycles (NUM_PAGES x PAGE_TOTAL, where PAGE_TOTAL = PAGE_BYTES + PAGE_BYTES/32) while every byte is set to 0xFF. `done`, `err`, `rd_valid` and `wr_ready` are low during this time.
- R2: A load (req_op = 2'b01) streams the bytes from page base + column + offset through the last spare byte of that page. `rd_last` marks the final byte. When that start point is at or beyond PAGE_TOTAL, no byte is streamed and `done` follows at once.
- R3: A program (req_op = 2'b10) takes bytes until the beat with `wr_last`. Each byte that falls inside the page, counting from column + offset, becomes stored AND new. Bytes past the page end are taken and dropped.
- R4: An erase (req_op = 2'b11) clears the low ERASE_SHIFT bits of the page number and sets every byte of the 2^ERASE_SHIFT pages in that block, spare bytes included, to 0xFF. This takes exactly BLOCK_BYTES cycles before `done`. Other blocks keep their data.
- R5: A request whose page number (req_addr >> COL_BITS) is NUM_PAGES or more changes no byte and sets `err`. A load of such a page streams nothing. A program of such a page still takes its bytes up to `wr_last`.
- R6: `err` is written only when a request is accepted. It holds its value while idle, and the next accepted in-range request clears it.
- R7: `off_set` latches `off_value` as the offset added to the column. A completed in-range program clears it to zero. Loads and erases leave it unchanged.
- R8: `done` is high for one cycle, the cycle after the last byte of a request. `busy` is high from the cycle after acceptance through that cycle. `req_start` while busy, or with req_op = 2'b00, is ignored.
- R9: While `rd_valid` is high and `rd_ready` is low, `rd_valid` and `rd_data` hold. `wr_ready` is high only while a program request is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 01 load, 10 program, 11 erase, 00 none |
| req_addr | input | ADDR_W | Page number above COL_BITS column bits |
| off_set | input | 1 | Latch a new column offset |
| off_value | input | COL_BITS+1 | Offset value |
| busy | output | 1 | Sweep or request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Last accepted request named an out-of-range page |
| wr_valid | input | 1 | Program byte valid |
| wr_ready | output | 1 | Program byte accepted |
| wr_data | input | 8 | Program byte |
| wr_last | input | 1 | Final program byte |
| rd_valid | output | 1 | Load byte valid |
| rd_ready | input | 1 | Load byte taken |
| rd_data | output | 8 | Load byte |
| rd_last | output | 1 | Final byte of the page |

## Verification
A request is taken at the clock edge where `req_start` is seen. The new state, and with it `err`, is visible from the next falling edge. An out-of-range or empty request shows `done` at that same falling edge. A load or program shows `done` one cycle after the beat that carried the last byte. An erase shows `done` exactly BLOCK_BYTES cycles after acceptance, and the initial sweep drops `busy` MEM_BYTES cycles after reset is released. The bench drives and samples only on falling edges. It counts cycles from acceptance to compare against these figures, and it compares stream bytes against its own array model as each beat is seen.

// File: rtl/nand_eng_pkg.sv
package nand_eng_pkg;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_PROG  = 2'd2,
    OP_ERASE = 2'd3
  } eng_op_e;

  typedef enum logic [2:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOAD,
    ST_PROG,
    ST_DRAIN,
    ST_ERASE,
    ST_DONE
  } eng_st_e;

  function automatic int spare_of(int page_bytes);
    return page_bytes / 32;
  endfunction

endpackage

// File: rtl/nand_addr_decode.sv
module nand_addr_decode #(
  parameter int ADDR_W      = 16,
  parameter int COL_BITS    = 8,
  parameter int NUM_PAGES   = 32,
  parameter int PAGE_TOTAL  = 66,
  parameter int ERASE_SHIFT = 4,
  parameter int AW          = 12
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                page_ok,
  output logic [AW-1:0]       page_base,
  output logic [AW-1:0]       block_base,
  output logic [COL_BITS-1:0] col
);
  localparam int PAGE_W      = ADDR_W - COL_BITS;
  localparam int PG_W        = $clog2(NUM_PAGES);
  localparam int BLOCK_PAGES = 1 << ERASE_SHIFT;
  localparam int MEM_BYTES   = NUM_PAGES * PAGE_TOTAL;
  localparam logic [PG_W-1:0] BLK_MASK = ~PG_W'(BLOCK_PAGES - 1);

  logic [PAGE_W-1:0] page_num;
  logic [PG_W-1:0]   page_idx;
  logic [PG_W-1:0]   blk_idx;

  assign page_num   = addr[ADDR_W-1:COL_BITS];
  assign page_idx   = page_num[PG_W-1:0];
  assign blk_idx    = page_idx & BLK_MASK;
  assign col        = addr[COL_BITS-1:0];
  assign page_ok    = (page_num < PAGE_W'(NUM_PAGES));
  assign page_base  = AW'(page_idx) * AW'(PAGE_TOTAL);
  assign block_base = AW'(blk_idx) * AW'(PAGE_TOTAL);

  // a_r5_base_in_range: an accepted page never maps past the array end
  always_comb begin
    a_r5_base_in_range: assert (!page_ok || (int'(page_base) + PAGE_TOTAL <= MEM_BYTES));
  end
endmodule

// File: rtl/nand_byte_store.sv
module nand_byte_store #(
  parameter int MEM_BYTES = 2112,
  parameter int AW        = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_and,
  input  logic          we_fill,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata
);
  logic [7:0] mem_q [MEM_BYTES];
  logic [7:0] old_byte;

  assign old_byte = mem_q[addr];
  assign rdata    = old_byte;

  always_ff @(posedge clk) begin
    if (we_fill) begin
      mem_q[addr] <= 8'hFF;
    end else if (we_and) begin
      mem_q[addr] <= old_byte & wdata;
    end
  end

  // R3: a program beat may only clear bits of the addressed byte
  a_r3_bits_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
    we_and && !we_fill |=> ((mem_q[$past(addr)] & ~$past(old_byte)) == 8'h00));

  // R4: a fill beat leaves the addressed byte at all ones
  a_r4_fill_ones: assert property (@(posedge clk) disable iff (!rst_n)
    we_fill |=> (mem_q[$past(addr)] == 8'hFF));

  a_r3_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_and && we_fill));
endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_eng_pkg::*;
#(
  parameter int PAGE_TOTAL  = 66,
  parameter int BLOCK_BYTES = 1056,
  parameter int MEM_BYTES   = 2112,
  parameter int AW          = 12,
  parameter int COL_BITS    = 8,
  parameter int OFF_W       = 9,
  parameter int CNT_W       = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_start,
  input  logic [1:0]          req_op,
  input  logic                page_ok,
  input  logic [AW-1:0]       page_base,
  input  logic [AW-1:0]       block_base,
  input  logic [COL_BITS-1:0] col,
  input  logic                off_set,
  input  logic [OFF_W-1:0]    off_value,
  input  logic                wr_valid,
  input  logic                wr_last,
  input  logic                rd_ready,
  output logic                busy,
  output logic                done,
  output logic                err,
  output logic                wr_ready,
  output logic                rd_valid,
  output logic                rd_last,
  output logic                we_and,
  output logic                we_fill,
  output logic [AW-1:0]       mem_addr
);
  localparam logic [CNT_W-1:0] PT_C     = CNT_W'(PAGE_TOTAL);
  localparam logic [CNT_W-1:0] PT_LAST  = CNT_W'(PAGE_TOTAL - 1);
  localparam logic [CNT_W-1:0] BB_LAST  = CNT_W'(BLOCK_BYTES - 1);
  localparam logic [CNT_W-1:0] MEM_LAST = CNT_W'(MEM_BYTES - 1);

  eng_st_e          st_q;
  logic [CNT_W-1:0] pos_q;
  logic [AW-1:0]    base_q;
  logic [OFF_W-1:0] off_q;
  logic             err_q;
  logic [CNT_W-1:0] start_pos;
  logic             in_page;
  logic             accept;
  logic             prog_end;

  assign start_pos = CNT_W'(col) + CNT_W'(off_q);
  assign in_page   = (pos_q < PT_C);
  assign accept    = (st_q == ST_IDLE) && req_start && (req_op != OP_NONE);
  assign prog_end  = (st_q == ST_PROG) && wr_valid && wr_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_INIT;
      pos_q  <= '0;
      base_q <= '0;
      off_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      if (prog_end) begin
        off_q <= '0;
      end else if (off_set) begin
        off_q <= off_value;
      end
      unique case (st_q)
        ST_INIT: begin
          if (pos_q == MEM_LAST) begin
            st_q  <= ST_IDLE;
            pos_q <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_IDLE: begin
          if (accept) begin
            err_q  <= !page_ok;
            pos_q  <= start_pos;
            base_q <= page_base;
            unique case (eng_op_e'(req_op))
              OP_LOAD:  st_q <= (page_ok && (start_pos < PT_C)) ? ST_LOAD : ST_DONE;
              OP_PROG:  st_q <= page_ok ? ST_PROG : ST_DRAIN;
              OP_ERASE: begin
                base_q <= block_base;
                pos_q  <= '0;
                st_q   <= page_ok ? ST_ERASE : ST_DONE;
              end
              default:  st_q <= ST_IDLE;
            endcase
          end
        end
        ST_LOAD: begin
          if (rd_ready) begin
            if (pos_q == PT_LAST) st_q <= ST_DONE;
            else                  pos_q <= pos_q + 1'b1;
          end
        end
        ST_PROG, ST_DRAIN: begin
          if (wr_valid) begin
            if (in_page) pos_q <= pos_q + 1'b1;
            if (wr_last) st_q <= ST_DONE;
          end
        end
        ST_ERASE: begin
          if (pos_q == BB_LAST) st_q <= ST_DONE;
          else                  pos_q <= pos_q + 1'b1;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st_q != ST_IDLE);
  assign done     = (st_q == ST_DONE);
  assign err      = err_q;
  assign wr_ready = (st_q == ST_PROG) || (st_q == ST_DRAIN);
  assign rd_valid = (st_q == ST_LOAD);
  assign rd_last  = rd_valid && (pos_q == PT_LAST);
  assign we_and   = (st_q == ST_PROG) && wr_valid && in_page;
  assign we_fill  = (st_q == ST_ERASE) || (st_q == ST_INIT);
  assign mem_addr = base_q + AW'(pos_q);

  // R8: done lasts one cycle and always falls inside busy
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  // R9: a stalled read beat keeps its valid and its source byte
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(mem_addr));
  a_r9_no_both_streams: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_valid));
  // R5: a flagged request never touches the array
  a_r5_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !we_and && !we_fill);
  // R6: err only rises on the edge that takes a request
  a_r6_err_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(req_start) && !$past(busy));
  // R7: a finished program leaves a zero offset
  a_r7_offset_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    prog_end |=> (off_q == '0));
endmodule

// File: rtl/nand_array_engine.sv
module nand_array_engine
  import nand_eng_pkg::*;
#(
  parameter int PAGE_BYTES  = 64,
  parameter int NUM_PAGES   = 32,
  parameter int ERASE_SHIFT = 4,
  parameter int COL_BITS    = 8,
  parameter int ADDR_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_start,
  input  logic [1:0]          req_op,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic                off_set,
  input  logic [COL_BITS:0]   off_value,
  output logic                busy,
  output logic                done,
  output logic                err,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [7:0]          wr_data,
  input  logic                wr_last,
  output logic                rd_valid,
  input  logic                rd_ready,
  output logic [7:0]          rd_data,
  output logic                rd_last
);
  localparam int PAGE_TOTAL  = PAGE_BYTES + spare_of(PAGE_BYTES);
  localparam int BLOCK_BYTES = (1 << ERASE_SHIFT) * PAGE_TOTAL;
  localparam int MEM_BYTES   = NUM_PAGES * PAGE_TOTAL;
  localparam int AW          = $clog2(MEM_BYTES);
  localparam int OFF_W       = COL_BITS + 1;
  localparam int CNT_W       = $clog2(MEM_BYTES + (1 << OFF_W) + 1);

  logic                page_ok;
  logic [AW-1:0]       page_base;
  logic [AW-1:0]       block_base;
  logic [COL_BITS-1:0] col;
  logic                we_and;
  logic                we_fill;
  logic [AW-1:0]       mem_addr;

  nand_addr_decode #(
    .ADDR_W(ADDR_W), .COL_BITS(COL_BITS), .NUM_PAGES(NUM_PAGES),
    .PAGE_TOTAL(PAGE_TOTAL), .ERASE_SHIFT(ERASE_SHIFT), .AW(AW)
  ) u_dec (
    .addr(req_addr), .page_ok(page_ok), .page_base(page_base),
    .block_base(block_base), .col(col)
  );

  nand_seq_ctrl #(
    .PAGE_TOTAL(PAGE_TOTAL), .BLOCK_BYTES(BLOCK_BYTES), .MEM_BYTES(MEM_BYTES),
    .AW(AW), .COL_BITS(COL_BITS), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_op(req_op),
    .page_ok(page_ok), .page_base(page_base), .block_base(block_base),
    .col(col), .off_set(off_set), .off_value(off_value),
    .wr_valid(wr_valid), .wr_last(wr_last), .rd_ready(rd_ready),
    .busy(busy), .done(done), .err(err), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_last(rd_last), .we_and(we_and),
    .we_fill(we_fill), .mem_addr(mem_addr)
  );

  nand_byte_store #(.MEM_BYTES(MEM_BYTES), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we_and(we_and), .we_fill(we_fill),
    .addr(mem_addr), .wdata(wr_data), .rdata(rd_data)
  );
endmodule

// File: tb/nand_array_engine_tb_top.sv
`timescale 1ns/1ps
module nand_array_engine_tb_top;
  localparam int PB = 64;
  localparam int NP = 32;
  localparam int ES = 4;
  localparam int PT = PB + PB / 32;
  localparam int BB = (1 << ES) * PT;
  localparam int MB = NP * PT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_start = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [15:0] req_addr = '0;
  logic off_set = 1'b0;
  logic [8:0] off_value = '0;
  logic busy, done, err, wr_ready, rd_valid, rd_last;
  logic wr_valid = 1'b0;
  logic wr_last = 1'b0;
  logic rd_ready = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;

  always #5 clk = ~clk;

  nand_array_engine #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .ERASE_SHIFT(ES),
                      .COL_BITS(8), .ADDR_W(16)) dut_i (.*);

  logic [7:0] ref_mem [MB];
  int n_chk = 0;
  int n_bad = 0;
  int off_m = 0;

  typedef struct packed {
    logic [1:0] op; logic [7:0] page; logic [7:0] col;
    logic [8:0] off; logic [7:0] seed; logic [7:0] len;
  } vec_t;

  localparam vec_t VT [17] = '{
    '{2'd2, 8'd0,   8'd0,  9'd0,  8'h3C, 8'd66},
    '{2'd1, 8'd0,   8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd2, 8'd0,   8'd10, 9'd0,  8'hA5, 8'd20},
    '{2'd1, 8'd0,   8'd5,  9'd0,  8'h00, 8'd0},
    '{2'd2, 8'd3,   8'd60, 9'd0,  8'hF0, 8'd10},
    '{2'd1, 8'd3,   8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd2, 8'd17,  8'd0,  9'd32, 8'h77, 8'd40},
    '{2'd1, 8'd17,  8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd2, 8'd40,  8'd0,  9'd0,  8'h00, 8'd5},
    '{2'd1, 8'd8,   8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd3, 8'd3,   8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd1, 8'd0,   8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd1, 8'd17,  8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd1, 8'd3,   8'd70, 9'd0,  8'h00, 8'd0},
    '{2'd3, 8'd200, 8'd0,  9'd0,  8'h00, 8'd0},
    '{2'd1, 8'd17,  8'd0,  9'd4,  8'h00, 8'd0},
    '{2'd1, 8'd17,  8'd0,  9'd0,  8'h00, 8'd0}
  };

  function automatic logic [7:0] pat(logic [7:0] s, int i);
    return s ^ 8'(i * 29);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(int op, int page, int col);
    @(negedge clk);
    req_start = 1'b1; req_op = 2'(op); req_addr = {8'(page), 8'(col)};
    @(negedge clk);
    req_start = 1'b0;
  endtask

  task automatic set_offset(int v);
    @(negedge clk); off_set = 1'b1; off_value = 9'(v);
    @(negedge clk); off_set = 1'b0;
    off_m = v;
  endtask

  task automatic do_prog(int page, int col, logic [7:0] seed, int len);
    bit ok = (page < NP);
    int pos = col + off_m;
    issue(2, page, col);
    for (int i = 0; i < len; i++) begin
      wr_data = pat(seed, i); wr_valid = 1'b1; wr_last = (i == len - 1);
      while (!wr_ready) @(negedge clk);
      @(negedge clk);
      if (ok && pos < PT) ref_mem[page * PT + pos] &= pat(seed, i);
      pos++;
    end
    wr_valid = 1'b0; wr_last = 1'b0;
    chk(done === 1'b1, ok ? "R3 done after last beat" : "R5 drain done", int'(done), 1);
    chk(err === !ok, "R5 program err flag", int'(err), int'(!ok));
    if (ok) off_m = 0;
    @(negedge clk);
  endtask

  task automatic drain_load(int page, int col, string tag);
    bit ok = (page < NP);
    int start = col + off_m;
    int exp_n = (ok && start < PT) ? PT - start : 0;
    int got = 0;
    int bad = 0;
    int guard = 0;
    int idx;
    rd_ready = 1'b1;
    while (!done && guard < 1000) begin
      if (rd_valid) begin
        idx = page * PT + start + got;
        if (idx < MB && rd_data !== ref_mem[idx]) begin
          if (bad == 0) chk(0, {tag, " load byte"}, int'(rd_data), int'(ref_mem[idx]));
          bad++;
        end
        if (rd_last !== (got == exp_n - 1)) begin
          if (bad == 0) chk(0, "R2 last marker", int'(rd_last), int'(got == exp_n - 1));
          bad++;
        end
        got++;
      end
      @(negedge clk);
      guard++;
    end
    chk(bad == 0, {tag, " load data"}, bad, 0);
    chk(got == exp_n, "R2 streamed byte count", got, exp_n);
    chk(err === !ok, "R5 load err flag", int'(err), int'(!ok));
    rd_ready = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_load(int page, int col, string tag);
    issue(1, page, col);
    drain_load(page, col, tag);
  endtask

  task automatic do_erase(int page);
    bit ok = (page < NP);
    int k = 0;
    int b;
    issue(3, page, 0);
    while (!done && k < 5000) begin @(negedge clk); k++; end
    chk(k == (ok ? BB : 0), ok ? "R4 erase cycle count" : "R5 erase rejected", k, ok ? BB : 0);
    chk(err === !ok, "R5 erase err flag", int'(err), int'(!ok));
    if (ok) begin
      b = (page & ~((1 << ES) - 1)) * PT;
      for (int j = 0; j < BB; j++) ref_mem[b + j] = 8'hFF;
    end
    @(negedge clk);
  endtask

  initial begin
    #2000000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int k;
    for (int j = 0; j < MB; j++) ref_mem[j] = 8'hFF;
    repeat (3) @(negedge clk);
    chk(done === 1'b0 && err === 1'b0, "R1 reset outputs", int'({done, err}), 0);
    chk(rd_valid === 1'b0 && wr_ready === 1'b0, "R1 reset streams", int'({rd_valid, wr_ready}), 0);
    rst_n = 1'b1;
    k = 0;
    while (busy && k < 5000) begin @(negedge clk); k++; end
    chk(k == MB, "R1 sweep length", k, MB);
    do_load(5, 0, "R1");

    foreach (VT[v]) begin
      if (VT[v].off != 0) set_offset(int'(VT[v].off));
      case (VT[v].op)
        2'd1: do_load(int'(VT[v].page), int'(VT[v].col), "R2");
        2'd2: do_prog(int'(VT[v].page), int'(VT[v].col), VT[v].seed, int'(VT[v].len));
        default: do_erase(int'(VT[v].page));
      endcase
    end

    // R6: err survives idle cycles and clears on the next in-range request
    do_prog(45, 0, 8'h11, 3);
    repeat (3) @(negedge clk);
    chk(err === 1'b1, "R6 err held while idle", int'(err), 1);
    do_load(17, 0, "R6");
    chk(err === 1'b0, "R6 err cleared", int'(err), 0);

    // R9: stalled read beat holds, write side closed
    issue(1, 17, 2);
    repeat (3) begin
      chk(rd_valid === 1'b1 && rd_data === ref_mem[17 * PT + 2 + off_m],
          "R9 stalled beat held", int'(rd_data), int'(ref_mem[17 * PT + 2 + off_m]));
      chk(wr_ready === 1'b0, "R9 wr_ready outside program", int'(wr_ready), 0);
      @(negedge clk);
    end
    drain_load(17, 2, "R9");

    // R8: request during erase is dropped
    issue(3, 16, 0);
    k = 0;
    while (!done && k < 5000) begin
      if (k == 5) begin req_start = 1'b1; req_op = 2'd1; req_addr = 16'h0000; end
      else req_start = 1'b0;
      if (rd_valid) chk(0, "R8 load during erase", 1, 0);
      @(negedge clk); k++;
    end
    req_start = 1'b0;
    chk(k == BB, "R8 erase unaffected by extra request", k, BB);
    for (int j = 16 * PT; j < 32 * PT; j++) ref_mem[j] = 8'hFF;
    @(negedge clk);
    chk(busy === 1'b0 && rd_valid === 1'b0 && done === 1'b0, "R8 dropped request left no trace",
        int'({busy, rd_valid, done}), 0);
    do_load(17, 0, "R4");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule